// File: doc/BRIEF.md
# Bus-Matching Width Converter for a Long-Word Queue

This block joins one queue, stored as 36-bit long words, to a write port and a read port whose widths are fixed at master reset. Each port moves 36-bit long words, 18-bit words or 9-bit bytes, and at least one of the two ports is always 36 bits wide. A narrow write port has its transfers gathered into long words. A narrow read port has each long word handed out one unit at a time. In both directions the first narrow transfer maps to the least significant end of the long word.

The two status flags each count in their own port's units. The full flag reflects how many write-width transfers still fit. The output-valid flag reflects whether a complete read-width unit is ready. A long word that the write side has only partly assembled stays invisible to the reader. A long word that the read side has only partly drained keeps holding its storage slot.

Top module: `bmc_width_converter`

## Requirements
- R1: While reset is held and right after it is released, `wr_full_n` is 1 (room) and `rd_valid_n` is 1 (nothing to read).
- R2: The port widths are loaded from `cfg_bm`, `cfg_iw` and `cfg_ow` only while reset is active, and later changes on those pins have no effect. The pin mapping (write/read) is: bm=0 gives 36/36 whatever the other two pins are; bm=1 with (iw,ow)=(0,0) gives 36/18; (0,1) gives 36/9; (1,0) gives 18/36; (1,1) gives 9/36.
- R3: With a narrow write port, consecutive write transfers fill a long word from bit 0 upward. The k-th transfer (k from 0) occupies bits [k*W + W-1 : k*W], where W is the write width. Only the low W bits of `wr_data` are used.
- R4: With a narrow read port, the k-th read unit of a long word is taken from bits [k*W + W-1 : k*W], where W is the read width. It appears on the low W bits of `rd_data`, and the upper bits are 0.
- R5: In 36/36 mode, long words are read back in the order they were written, without change.
- R6: `rd_valid_n` goes to 0 only once a complete read-width unit is held. In 18/36 mode, one write into an empty queue leaves it at 1, and the second write drives it to 0.
- R7: `wr_full_n` counts in write units. In 36/9 mode with the store full, three reads leave `wr_full_n` at 0, and the fourth read sets it to 1.
- R8: A write presented while `wr_full_n` is 0 is discarded. The data read back afterwards contains none of it.
- R9: A read presented while `rd_valid_n` is 1 is discarded, and the data read later is not shifted by it.
- R10: A write and a read may both be accepted in the same cycle in every mode, and the data order is preserved.
- R11: With DEPTH long words of storage and a write port of N transfers per long word, `wr_full_n` falls after exactly DEPTH*N + N - 1 accepted writes into an empty queue. The packer may hold one partial long word beyond the store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low master reset, released synchronously |
| cfg_bm | input | 1 | Width setup pin: 0 selects 36/36 |
| cfg_iw | input | 1 | Width setup pin: narrow write side select |
| cfg_ow | input | 1 | Width setup pin: narrow read side select |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Write data; only the low write-width bits are used |
| wr_full_n | output | 1 | 0 when no further write-width transfer fits |
| rd_en | input | 1 | Read request |
| rd_data | output | 36 | Current read unit, zero-extended |
| rd_valid_n | output | 1 | 0 when `rd_data` holds a valid unit |

## Verification
Every width mode is driven with filling bursts, draining bursts and mixed simultaneous traffic. A byte-level reference queue compares each read unit and both flags in every cycle, which separates a wrong slice order from a wrong flag unit. Dedicated patterns write one unit short of a full long word, to tell whether output-valid counts in read units or in writes. Reads are made from a full store one unit at a time, to tell whether the slot is released on the last unit or the first. Writes into a full store and reads from an empty one are followed by a complete drain, which shows whether the discarded transfer left any trace in the data.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  localparam int UNITS_PER_LONG = 4;

  typedef enum logic [2:0] {
    M_36_36 = 3'd0,
    M_36_18 = 3'd1,
    M_36_9  = 3'd2,
    M_18_36 = 3'd3,
    M_9_36  = 3'd4
  } bmc_mode_e;

  function automatic bmc_mode_e mode_decode(input logic bm, input logic iw, input logic ow);
    if (!bm) return M_36_36;
    case ({iw, ow})
      2'b00:   return M_36_18;
      2'b01:   return M_36_9;
      2'b10:   return M_18_36;
      default: return M_9_36;
    endcase
  endfunction

  // log2 of the number of byte units per write transfer
  function automatic logic [1:0] wr_lg(input bmc_mode_e m);
    case (m)
      M_18_36: return 2'd1;
      M_9_36:  return 2'd0;
      default: return 2'd2;
    endcase
  endfunction

  // log2 of the number of byte units per read transfer
  function automatic logic [1:0] rd_lg(input bmc_mode_e m);
    case (m)
      M_36_18: return 2'd1;
      M_36_9:  return 2'd0;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/bmc_rst_sync.sv
module bmc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_q = stage_q[1];
endmodule

// File: rtl/bmc_wr_pack.sv
module bmc_wr_pack #(
  parameter  int UNIT_W = 9,
  localparam int LW     = 4 * UNIT_W,
  localparam int HW     = 3 * UNIT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    lg,
  input  logic          wr_go,
  input  logic [LW-1:0] wr_data,
  output logic          last_slot,
  output logic          push,
  output logic [LW-1:0] push_word,
  output logic [1:0]    sub
);
  logic [HW-1:0] hold_q, hold_d;
  logic [1:0]    sub_q, sub_d;
  logic [1:0]    last_idx;
  logic [1:0]    off;

  assign last_idx  = 2'((3'd4 >> lg) - 3'd1);
  assign last_slot = (sub_q == last_idx);
  assign off       = 2'(sub_q << lg);
  assign push      = wr_go && last_slot;
  assign sub       = sub_q;

  always_comb begin
    hold_d = hold_q;
    if (wr_go && !last_slot) begin
      for (int b = 0; b < 3; b++) begin
        if (b >= int'(off) && b < int'(off) + (1 << lg))
          hold_d[b*UNIT_W +: UNIT_W] = wr_data[(b - int'(off))*UNIT_W +: UNIT_W];
      end
    end
  end

  always_comb begin
    case (lg)
      2'd2:    push_word = wr_data;
      2'd1:    push_word = {wr_data[2*UNIT_W-1:0], hold_q[2*UNIT_W-1:0]};
      default: push_word = {wr_data[UNIT_W-1:0], hold_q};
    endcase
  end

  always_comb begin
    sub_d = sub_q;
    if (wr_go) sub_d = last_slot ? 2'd0 : sub_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      sub_q  <= '0;
    end else begin
      hold_q <= hold_d;
      sub_q  <= sub_d;
    end
  end
endmodule

// File: rtl/bmc_word_store.sv
module bmc_word_store #(
  parameter  int LW    = 36,
  parameter  int DEPTH = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [LW-1:0] push_word,
  input  logic          pop,
  output logic [LW-1:0] head_word,
  output logic [CW-1:0] count
);
  logic [LW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_d  = push ? bump(wp_q) : wp_q;
    rp_d  = pop  ? bump(rp_q) : rp_q;
    cnt_d = cnt_q;
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wp_q] <= push_word;
  end

  assign head_word = mem_q[rp_q];
  assign count     = cnt_q;
endmodule

// File: rtl/bmc_rd_unpack.sv
module bmc_rd_unpack #(
  parameter  int UNIT_W = 9,
  localparam int LW     = 4 * UNIT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    lg,
  input  logic [LW-1:0] head_word,
  input  logic          avail,
  input  logic          rd_en,
  output logic [LW-1:0] rd_data,
  output logic          pop,
  output logic [1:0]    sub
);
  logic [1:0] sub_q, sub_d;
  logic [1:0] last_idx;
  logic       rd_go;

  assign last_idx = 2'((3'd4 >> lg) - 3'd1);
  assign rd_go    = rd_en && avail;
  assign pop      = rd_go && (sub_q == last_idx);
  assign sub      = sub_q;

  always_comb begin
    rd_data = '0;
    case (lg)
      2'd2: rd_data = head_word;
      2'd1: rd_data[2*UNIT_W-1:0] = head_word[sub_q[0]*2*UNIT_W +: 2*UNIT_W];
      default: rd_data[UNIT_W-1:0] = head_word[sub_q*UNIT_W +: UNIT_W];
    endcase
  end

  always_comb begin
    sub_d = sub_q;
    if (rd_go) sub_d = (sub_q == last_idx) ? 2'd0 : sub_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sub_q <= '0;
    else        sub_q <= sub_d;
  end
endmodule

// File: rtl/bmc_width_converter.sv
module bmc_width_converter #(
  parameter  int UNIT_W = 9,
  parameter  int DEPTH  = 8,
  localparam int LW     = bmc_pkg::UNITS_PER_LONG * UNIT_W,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_bm,
  input  logic          cfg_iw,
  input  logic          cfg_ow,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_data,
  output logic          wr_full_n,
  input  logic          rd_en,
  output logic [LW-1:0] rd_data,
  output logic          rd_valid_n
);
  import bmc_pkg::*;

  logic          rst_q;
  bmc_mode_e     mode_q;
  logic [1:0]    wlg, rlg;
  logic          wr_go, wr_last, push, pop, full;
  logic [LW-1:0] push_word, head_word;
  logic [CW-1:0] word_cnt;
  logic [1:0]    wr_sub, rd_sub;

  bmc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q(rst_q));

  // widths follow the setup pins only while reset is active
  always_ff @(posedge clk) begin
    if (!rst_q) mode_q <= mode_decode(cfg_bm, cfg_iw, cfg_ow);
  end

  assign wlg   = wr_lg(mode_q);
  assign rlg   = rd_lg(mode_q);
  assign full  = (int'(word_cnt) == DEPTH) && wr_last;
  assign wr_go = wr_en && !full;

  bmc_wr_pack #(.UNIT_W(UNIT_W)) u_pack (
    .clk(clk), .rst_n(rst_q), .lg(wlg), .wr_go(wr_go), .wr_data(wr_data),
    .last_slot(wr_last), .push(push), .push_word(push_word), .sub(wr_sub)
  );

  bmc_word_store #(.LW(LW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_q), .push(push), .push_word(push_word),
    .pop(pop), .head_word(head_word), .count(word_cnt)
  );

  bmc_rd_unpack #(.UNIT_W(UNIT_W)) u_unpack (
    .clk(clk), .rst_n(rst_q), .lg(rlg), .head_word(head_word),
    .avail(word_cnt != '0), .rd_en(rd_en), .rd_data(rd_data),
    .pop(pop), .sub(rd_sub)
  );

  assign wr_full_n  = !full;
  assign rd_valid_n = (word_cnt == '0);
endmodule

// File: rtl/bmc_checker.sv
module bmc_checker #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_q,
  input logic [2:0]    mode_q,
  input logic [1:0]    wlg,
  input logic [1:0]    rlg,
  input logic [CW-1:0] word_cnt,
  input logic [1:0]    wr_sub,
  input logic [1:0]    rd_sub,
  input logic          wr_en,
  input logic          rd_en,
  input logic          wr_full_n,
  input logic          rd_valid_n
);
  // R1
  reset_flags_chk: assert property (@(posedge clk) $rose(rst_q) |-> (wr_full_n && rd_valid_n));

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $past(rst_q) |-> $stable(mode_q));

  // R3
  wr_sub_range_chk: assert property (@(posedge clk) disable iff (!rst_q)
    int'(wr_sub) < (4 >> wlg));

  // R4
  rd_sub_range_chk: assert property (@(posedge clk) disable iff (!rst_q)
    int'(rd_sub) < (4 >> rlg));

  // R8
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!wr_full_n && wr_en && !rd_en) |=> (word_cnt == $past(word_cnt) && wr_sub == $past(wr_sub)));

  // R9
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_valid_n && rd_en && !wr_en) |=> (rd_valid_n && rd_sub == $past(rd_sub)));

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_q)
    int'(word_cnt) <= DEPTH);
endmodule

bind bmc_width_converter bmc_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_q(rst_q), .mode_q(mode_q), .wlg(wlg), .rlg(rlg),
  .word_cnt(word_cnt), .wr_sub(wr_sub), .rd_sub(rd_sub), .wr_en(wr_en),
  .rd_en(rd_en), .wr_full_n(wr_full_n), .rd_valid_n(rd_valid_n)
);

// File: tb/bmc_width_converter_test.sv
module bmc_width_converter_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;

  logic        clk = 1'b0;
  logic        rst_n, cfg_bm, cfg_iw, cfg_ow, wr_en, rd_en;
  logic [35:0] wr_data;
  logic        wr_full_n, rd_valid_n;
  logic [35:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  string cur_req = "R1";

  // reference model, byte granular
  logic [8:0] q[$];
  int wb, rb, wr_total, rd_total;

  always #(CLK_PERIOD/2) clk = ~clk;

  bmc_width_converter #(.UNIT_W(9), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_bm(cfg_bm), .cfg_iw(cfg_iw), .cfg_ow(cfg_ow),
    .wr_en(wr_en), .wr_data(wr_data), .wr_full_n(wr_full_n),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid_n(rd_valid_n)
  );

  task automatic ck(input bit ok, input string what, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  function automatic bit m_valid();
    return ((wr_total / 4) * 4 - rd_total) >= rb;
  endfunction

  function automatic bit m_full();
    int words = wr_total / 4 - rd_total / 4;
    int wsub  = (wr_total % 4) / wb;
    return (words == DEPTH) && (wsub == 4 / wb - 1);
  endfunction

  function automatic logic [35:0] m_head();
    logic [35:0] v = '0;
    for (int i = 0; i < rb; i++) v[i*9 +: 9] = q[i];
    return v;
  endfunction

  // called at a negative edge; returns at the next negative edge
  task automatic step(input bit we, input logic [35:0] wd, input bit re);
    bit aw, ar;
    wr_en = we; wr_data = wd; rd_en = re;
    ck(wr_full_n == !m_full(), "wr_full_n", 36'(wr_full_n), 36'(!m_full()));
    ck(rd_valid_n == !m_valid(), "rd_valid_n", 36'(rd_valid_n), 36'(!m_valid()));
    if (m_valid()) ck(rd_data == m_head(), "rd_data", rd_data, m_head());
    aw = we && !m_full();
    ar = re && m_valid();
    @(posedge clk);
    if (ar) begin
      for (int i = 0; i < rb; i++) void'(q.pop_front());
      rd_total += rb;
    end
    if (aw) begin
      for (int i = 0; i < wb; i++) q.push_back(wd[i*9 +: 9]);
      wr_total += wb;
    end
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  // widths per R2: write/read bytes for each pin combination
  task automatic do_reset(input bit bm, input bit iw, input bit ow);
    @(negedge clk);
    rst_n = 0; wr_en = 0; rd_en = 0; wr_data = '0;
    cfg_bm = bm; cfg_iw = iw; cfg_ow = ow;
    repeat (3) @(negedge clk);
    ck(wr_full_n === 1'b1 && rd_valid_n === 1'b1, "flags in reset (R1)",
       {34'd0, wr_full_n, rd_valid_n}, 36'd3);
    rst_n = 1;
    repeat (3) @(negedge clk);
    cfg_bm = !bm; cfg_iw = !iw; cfg_ow = !ow;   // R2: must be ignored now
    q.delete(); wr_total = 0; rd_total = 0;
    if (!bm)             begin wb = 4; rb = 4; end
    else if (!iw && !ow) begin wb = 4; rb = 2; end
    else if (!iw &&  ow) begin wb = 4; rb = 1; end
    else if ( iw && !ow) begin wb = 2; rb = 4; end
    else                 begin wb = 1; rb = 4; end
    ck(wr_full_n && rd_valid_n, "flags after reset (R1)", {34'd0, wr_full_n, rd_valid_n}, 36'd3);
  endtask

  task automatic t_passthrough();
    cur_req = "R5";
    do_reset(0, 1, 0);
    for (int i = 0; i < 5; i++) step(1, 36'h1_2345_6780 + 36'(i * 36'h1_0101_0101), 0);
    for (int i = 0; i < 5; i++) step(0, '0, 1);
  endtask

  task automatic t_pack();
    cur_req = "R3";
    do_reset(1, 1, 1);   // 9/36
    step(1, 36'hF_FFFF_F011, 0); step(1, 36'h0_0000_0022, 0);
    step(1, 36'hA_AAAA_A033, 0); step(1, 36'h0_0000_0144, 0);
    ck(rd_data == {9'h144, 9'h033, 9'h022, 9'h011}, "9-bit pack order", rd_data,
       {9'h144, 9'h033, 9'h022, 9'h011});
    step(0, '0, 1);
    do_reset(1, 1, 0);   // 18/36
    step(1, 36'h5_0001_2345, 0); step(1, 36'h0_0002_ABCD, 0);
    ck(rd_data == {18'h2ABCD, 18'h12345}, "18-bit pack order", rd_data, {18'h2ABCD, 18'h12345});
    step(0, '0, 1);
  endtask

  task automatic t_unpack();
    logic [35:0] w = 36'h9_8765_4321;
    cur_req = "R4";
    do_reset(1, 0, 1);   // 36/9, also shows R2 since pins were flipped
    step(1, w, 0);
    for (int k = 0; k < 4; k++) begin
      ck(rd_data == {27'd0, w[k*9 +: 9]}, "9-bit unpack slice", rd_data, {27'd0, w[k*9 +: 9]});
      step(0, '0, 1);
    end
    cur_req = "R2";
    ck(rd_valid_n == 1'b1, "latched 36/9 used four reads", 36'(rd_valid_n), 36'd1);
    cur_req = "R4";
    do_reset(1, 0, 0);   // 36/18
    step(1, w, 0);
    for (int k = 0; k < 2; k++) begin
      ck(rd_data == {18'd0, w[k*18 +: 18]}, "18-bit unpack slice", rd_data, {18'd0, w[k*18 +: 18]});
      step(0, '0, 1);
    end
  endtask

  task automatic t_valid_units();
    cur_req = "R6";
    do_reset(1, 1, 0);   // 18/36
    step(1, 36'h0_0000_1111, 0);
    ck(rd_valid_n == 1'b1, "half word not visible", 36'(rd_valid_n), 36'd1);
    step(1, 36'h0_0000_2222, 0);
    ck(rd_valid_n == 1'b0, "full word visible", 36'(rd_valid_n), 36'd0);
  endtask

  task automatic t_full_units();
    cur_req = "R7";
    do_reset(1, 0, 1);   // 36/9
    for (int i = 0; i < DEPTH; i++) step(1, 36'(i * 7 + 36'h3_0000_0001), 0);
    ck(wr_full_n == 1'b0, "full after DEPTH words", 36'(wr_full_n), 36'd0);
    for (int i = 0; i < 3; i++) step(0, '0, 1);
    ck(wr_full_n == 1'b0, "still full after 3 byte reads", 36'(wr_full_n), 36'd0);
    step(0, '0, 1);
    ck(wr_full_n == 1'b1, "room after 4th byte read", 36'(wr_full_n), 36'd1);
  endtask

  task automatic t_full_ignore();
    cur_req = "R8";
    do_reset(0, 0, 0);
    for (int i = 0; i < DEPTH; i++) step(1, 36'(36'h0_1000_0000 + i), 0);
    for (int i = 0; i < 3; i++) step(1, 36'hD_EADB_EEF0, 0);
    while (m_valid()) step(0, '0, 1);
    ck(rd_valid_n == 1'b1, "drained with no extra word", 36'(rd_valid_n), 36'd1);
  endtask

  task automatic t_empty_read();
    cur_req = "R9";
    do_reset(1, 0, 0);   // 36/18
    for (int i = 0; i < 3; i++) step(0, '0, 1);
    step(1, 36'h7_1234_5678, 0);
    ck(rd_data == {18'd0, 18'h05678}, "first slice after empty reads", rd_data, {18'd0, 18'h05678});
    step(0, '0, 1); step(0, '0, 1);
  endtask

  task automatic t_capacity();
    int n;
    cur_req = "R11";
    do_reset(1, 1, 1);   // 9/36
    n = 0;
    while (wr_full_n && n < 100) begin step(1, 36'(n), 0); n++; end
    ck(n == DEPTH * 4 + 3, "byte writes until full", 36'(n), 36'(DEPTH * 4 + 3));
    do_reset(1, 1, 0);   // 18/36
    n = 0;
    while (wr_full_n && n < 100) begin step(1, 36'(n), 0); n++; end
    ck(n == DEPTH * 2 + 1, "word writes until full", 36'(n), 36'(DEPTH * 2 + 1));
  endtask

  task automatic t_mixed();
    bit pins[5][3] = '{'{0,0,0}, '{1,0,0}, '{1,0,1}, '{1,1,0}, '{1,1,1}};
    cur_req = "R10";
    for (int m = 0; m < 5; m++) begin
      do_reset(pins[m][0], pins[m][1], pins[m][2]);
      for (int c = 0; c < 400; c++) begin
        int r = $urandom_range(0, 3);
        bit we = (c < 200) ? (r != 0) : (r == 0);
        bit re = (c < 200) ? (r <= 1) : (r != 3);
        step(we, {$urandom, $urandom} & 36'hF_FFFF_FFFF, re);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_bm = 0; cfg_iw = 0; cfg_ow = 0;
    wr_en = 0; rd_en = 0; wr_data = '0;
    wb = 4; rb = 4; wr_total = 0; rd_total = 0;
    t_passthrough();
    t_pack();
    t_unpack();
    t_valid_units();
    t_full_units();
    t_full_ignore();
    t_empty_read();
    t_capacity();
    t_mixed();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule